// File: doc/BRIEF.md
# Threshold Bit-Flip Error Locator and Corrector

This block carries out one flip decision of an iterative bit-flipping decoder whose vectors sit in word-organised memories of `NB` elements per word. After a `start` pulse it counts the ones in every syndrome word to form the syndrome weight. It uses that weight to select a flip threshold from a small programmable table of weight breakpoints. It then visits the correlation memory one word at a time and records each element that is strictly above the threshold as a (row, index) pair in an external error-position list. Last, it reads that list back and flips the recorded bits in the message memory with a read-modify-write of each affected word.

A syndrome weight of zero means decoding has already succeeded. In that case the block reports it, then skips both the scan and the correction. The error-position list has a fixed depth. Flips found after the list is full are dropped and raise a sticky overflow flag. All memories are outside the block, and each has a read latency of one clock cycle.

Top module: `bitflip_locator`

## Requirements
- R1: A `start` pulse while idle clears the weight, reads each of the `SROWS` syndrome words exactly once, and leaves `weight` equal to the total number of ones read.
- R2: The threshold comes from the table slot with the highest slot number whose breakpoint is less than or equal to the weight. If no slot matches, the threshold is all ones. A slot is written when `cfg_we` is high, at slot `cfg_slot`. Reset sets every breakpoint to 0 and every threshold to all ones.
- R3: Element j of a correlation word occupies bits `[j*CW +: CW]` and is unsigned. It is flagged only if it is strictly greater than the threshold, so a value equal to the threshold is not flagged.
- R4: Flagged positions are written to the list in ascending row order and, within a row, in ascending index order, one write per cycle, at slots 0, 1, 2 and so on. `err_count` equals the number of entries written.
- R5: Once `LDEPTH` entries have been written, any further flagged position is dropped and `overflow` rises. `overflow` stays high until the next accepted `start`, which clears it.
- R6: Every message row that holds at least one recorded position is read once and written once, with bit j inverted for each recorded index j. Rows with no recorded position are not touched. Dropped positions are not applied.
- R7: A syndrome weight of zero sets `zero_syn`. The block then ends with no correlation read, no list write and no message write.
- R8: `busy` is high from the cycle after an accepted `start` until the cycle after `done`. `done` is a pulse one cycle long. A `start` that arrives while `busy` is high is ignored.
- R9: Each message write goes to the address read in the cycle just before it, with `msg_wdata` equal to the word read XOR the flip mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin one flip decision |
| busy | output | 1 | Decision in progress |
| done | output | 1 | One-cycle completion pulse |
| zero_syn | output | 1 | Syndrome weight was zero |
| overflow | output | 1 | Flips dropped because the list was full |
| weight | output | SW | Syndrome weight |
| err_count | output | LW | Entries written to the list |
| cfg_we | input | 1 | Table slot write enable |
| cfg_slot | input | TSW | Table slot number |
| cfg_brk | input | SW | Breakpoint weight for the slot |
| cfg_thr | input | CW | Threshold for the slot |
| syn_rd | output | 1 | Syndrome read strobe |
| syn_addr | output | SAW | Syndrome word address |
| syn_rdata | input | NB | Syndrome word, one cycle after the strobe |
| cor_rd | output | 1 | Correlation read strobe |
| cor_addr | output | CAW | Correlation word address |
| cor_rdata | input | NB*CW | Correlation word, one cycle after the strobe |
| err_we | output | 1 | List write strobe |
| err_waddr | output | LAW | List slot written |
| err_wrow | output | CAW | Row of the recorded position |
| err_widx | output | IW | In-row index of the recorded position |
| err_rd | output | 1 | List read strobe |
| err_raddr | output | LAW | List slot read |
| err_rrow | input | CAW | Row read back, one cycle after the strobe |
| err_ridx | input | IW | Index read back, one cycle after the strobe |
| msg_rd | output | 1 | Message read strobe |
| msg_we | output | 1 | Message write strobe |
| msg_addr | output | CAW | Message word address |
| msg_rdata | input | NB | Message word, one cycle after the strobe |
| msg_wdata | output | NB | Corrected message word |

## Verification
The bench builds the block with 8 elements per word, 5-bit correlation elements, 4 syndrome words, 6 correlation and message rows, 4 table slots and a list depth of 8. With 48 candidate positions against 8 list slots, both filling the list and overflowing it happen often under random data. A single dense row can also fill the whole list by itself. With 4 syndrome words the weight spans 0 to 32, so every table slot can be selected, as can the case where no slot matches.

// File: rtl/bfl_pkg.sv
package bfl_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WT,
        S_THR,
        S_CRD,
        S_CCAP,
        S_CREC,
        S_LREQ,
        S_LDAT,
        S_MRD,
        S_MWB,
        S_FIN
    } bfl_state_e;

endpackage

// File: rtl/bfl_popcnt.sv
module bfl_popcnt #(
    parameter int W  = 8,
    parameter int OW = 4
) (
    input  logic [W-1:0]  vec,
    output logic [OW-1:0] cnt
);

    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + OW'(vec[i]);
        end
    end

endmodule

// File: rtl/bfl_row_cmp.sv
module bfl_row_cmp #(
    parameter int NB = 8,
    parameter int CW = 5
) (
    input  logic [NB*CW-1:0] row,
    input  logic [CW-1:0]    thr,
    output logic [NB-1:0]    gt
);

    for (genvar j = 0; j < NB; j++) begin : g_elem
        assign gt[j] = row[j*CW +: CW] > thr;
    end

endmodule

// File: rtl/bfl_lowest.sv
module bfl_lowest #(
    parameter int NB = 8,
    parameter int IW = 3
) (
    input  logic [NB-1:0] vec,
    output logic [IW-1:0] idx,
    output logic [NB-1:0] oh
);

    always_comb begin
        idx = '0;
        for (int j = NB - 1; j >= 0; j--) begin
            if (vec[j]) idx = IW'(j);
        end
        oh = vec & (~vec + 1'b1);
    end

endmodule

// File: rtl/bfl_thr_table.sv
module bfl_thr_table #(
    parameter int NTHR = 4,
    parameter int SW   = 6,
    parameter int CW   = 5,
    parameter int TSW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [TSW-1:0] cfg_slot,
    input  logic [SW-1:0]  cfg_brk,
    input  logic [CW-1:0]  cfg_thr,
    input  logic [SW-1:0]  weight,
    output logic [CW-1:0]  thr
);

    logic [SW-1:0] brk_q [NTHR];
    logic [SW-1:0] brk_d [NTHR];
    logic [CW-1:0] val_q [NTHR];
    logic [CW-1:0] val_d [NTHR];

    always_comb begin
        for (int k = 0; k < NTHR; k++) begin
            brk_d[k] = brk_q[k];
            val_d[k] = val_q[k];
            if (cfg_we && (32'(cfg_slot) == k)) begin
                brk_d[k] = cfg_brk;
                val_d[k] = cfg_thr;
            end
        end
        // highest matching slot wins
        thr = '1;
        for (int k = 0; k < NTHR; k++) begin
            if (weight >= brk_q[k]) thr = val_q[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NTHR; k++) begin
                brk_q[k] <= '0;
                val_q[k] <= '1;
            end
        end else begin
            for (int k = 0; k < NTHR; k++) begin
                brk_q[k] <= brk_d[k];
                val_q[k] <= val_d[k];
            end
        end
    end

endmodule

// File: rtl/bitflip_locator.sv
module bitflip_locator
    import bfl_pkg::*;
#(
    parameter int NB     = 8,
    parameter int CW     = 5,
    parameter int SROWS  = 4,
    parameter int CROWS  = 6,
    parameter int NTHR   = 4,
    parameter int LDEPTH = 8,
    localparam int SW    = $clog2(SROWS * NB + 1),
    localparam int SAW   = (SROWS > 1) ? $clog2(SROWS) : 1,
    localparam int CAW   = (CROWS > 1) ? $clog2(CROWS) : 1,
    localparam int IW    = (NB > 1) ? $clog2(NB) : 1,
    localparam int LW    = $clog2(LDEPTH + 1),
    localparam int LAW   = (LDEPTH > 1) ? $clog2(LDEPTH) : 1,
    localparam int TSW   = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             zero_syn,
    output logic             overflow,
    output logic [SW-1:0]    weight,
    output logic [LW-1:0]    err_count,
    input  logic             cfg_we,
    input  logic [TSW-1:0]   cfg_slot,
    input  logic [SW-1:0]    cfg_brk,
    input  logic [CW-1:0]    cfg_thr,
    output logic             syn_rd,
    output logic [SAW-1:0]   syn_addr,
    input  logic [NB-1:0]    syn_rdata,
    output logic             cor_rd,
    output logic [CAW-1:0]   cor_addr,
    input  logic [NB*CW-1:0] cor_rdata,
    output logic             err_we,
    output logic [LAW-1:0]   err_waddr,
    output logic [CAW-1:0]   err_wrow,
    output logic [IW-1:0]    err_widx,
    output logic             err_rd,
    output logic [LAW-1:0]   err_raddr,
    input  logic [CAW-1:0]   err_rrow,
    input  logic [IW-1:0]    err_ridx,
    output logic             msg_rd,
    output logic             msg_we,
    output logic [CAW-1:0]   msg_addr,
    input  logic [NB-1:0]    msg_rdata,
    output logic [NB-1:0]    msg_wdata
);

    localparam logic [SAW:0] SROWS_W  = (SAW + 1)'(SROWS);
    localparam logic [CAW:0] CROWS_W  = (CAW + 1)'(CROWS);
    localparam logic [LW-1:0] LDEPTH_W = LW'(LDEPTH);

    typedef struct packed {
        bfl_state_e      st;
        logic [SAW:0]    wa;
        logic            spend;
        logic [SW-1:0]   wgt;
        logic [CW-1:0]   thr;
        logic [CAW:0]    ca;
        logic [NB-1:0]   gt;
        logic [LW-1:0]   cnt;
        logic            ovf;
        logic            zero;
        logic [LW-1:0]   li;
        logic [CAW-1:0]  crow;
        logic [NB-1:0]   mask;
        logic            mval;
        logic [CAW-1:0]  prow;
        logic [IW-1:0]   pidx;
        logic            fin;
    } regs_t;

    regs_t q, d;

    logic [SW-1:0] pop_cnt;
    logic [CW-1:0] tbl_thr;
    logic [NB-1:0] gt_vec;
    logic [IW-1:0] pick_idx;
    logic [NB-1:0] pick_oh;

    bfl_popcnt #(.W(NB), .OW(SW)) u_pop (
        .vec (syn_rdata),
        .cnt (pop_cnt)
    );

    bfl_thr_table #(.NTHR(NTHR), .SW(SW), .CW(CW), .TSW(TSW)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_slot (cfg_slot),
        .cfg_brk  (cfg_brk),
        .cfg_thr  (cfg_thr),
        .weight   (q.wgt),
        .thr      (tbl_thr)
    );

    bfl_row_cmp #(.NB(NB), .CW(CW)) u_cmp (
        .row (cor_rdata),
        .thr (q.thr),
        .gt  (gt_vec)
    );

    bfl_lowest #(.NB(NB), .IW(IW)) u_pick (
        .vec (q.gt),
        .idx (pick_idx),
        .oh  (pick_oh)
    );

    always_comb begin
        d         = q;
        syn_rd    = 1'b0;
        syn_addr  = q.wa[SAW-1:0];
        cor_rd    = 1'b0;
        cor_addr  = q.ca[CAW-1:0];
        err_we    = 1'b0;
        err_waddr = q.cnt[LAW-1:0];
        err_wrow  = q.ca[CAW-1:0];
        err_widx  = pick_idx;
        err_rd    = 1'b0;
        err_raddr = q.li[LAW-1:0];
        msg_rd    = 1'b0;
        msg_we    = 1'b0;
        msg_addr  = q.crow;
        msg_wdata = msg_rdata ^ q.mask;

        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.wgt   = '0;
                    d.cnt   = '0;
                    d.ovf   = 1'b0;
                    d.zero  = 1'b0;
                    d.wa    = '0;
                    d.spend = 1'b0;
                    d.st    = S_WT;
                end
            end
            // weight: reads issued back to back, summed one cycle later
            S_WT: begin
                if (q.wa < SROWS_W) begin
                    syn_rd = 1'b1;
                    d.wa   = q.wa + 1'b1;
                end
                d.spend = syn_rd;
                if (q.spend) d.wgt = q.wgt + pop_cnt;
                if (!syn_rd && !q.spend) d.st = S_THR;
            end
            S_THR: begin
                if (q.wgt == '0) begin
                    d.zero = 1'b1;
                    d.st   = S_FIN;
                end else begin
                    d.thr = tbl_thr;
                    d.ca  = '0;
                    d.st  = S_CRD;
                end
            end
            // scan: one correlation word per visit
            S_CRD: begin
                if (q.ca == CROWS_W) begin
                    d.li   = '0;
                    d.mval = 1'b0;
                    d.mask = '0;
                    d.st   = S_LREQ;
                end else begin
                    cor_rd = 1'b1;
                    d.st   = S_CCAP;
                end
            end
            S_CCAP: begin
                d.gt = gt_vec;
                d.st = S_CREC;
            end
            // drain flagged elements lowest index first
            S_CREC: begin
                if (q.gt == '0) begin
                    d.ca = q.ca + 1'b1;
                    d.st = S_CRD;
                end else begin
                    d.gt = q.gt & ~pick_oh;
                    if (q.cnt < LDEPTH_W) begin
                        err_we = 1'b1;
                        d.cnt  = q.cnt + 1'b1;
                    end else begin
                        d.ovf = 1'b1;
                    end
                end
            end
            // correction: gather same-row entries into one mask
            S_LREQ: begin
                if (q.li == q.cnt) begin
                    if (q.mval) begin
                        d.fin = 1'b1;
                        d.st  = S_MRD;
                    end else begin
                        d.st = S_FIN;
                    end
                end else begin
                    err_rd = 1'b1;
                    d.st   = S_LDAT;
                end
            end
            S_LDAT: begin
                if (q.mval && (err_rrow != q.crow)) begin
                    d.prow = err_rrow;
                    d.pidx = err_ridx;
                    d.fin  = 1'b0;
                    d.st   = S_MRD;
                end else begin
                    d.mask = q.mask | (NB'(1) << err_ridx);
                    d.crow = err_rrow;
                    d.mval = 1'b1;
                    d.li   = q.li + 1'b1;
                    d.st   = S_LREQ;
                end
            end
            S_MRD: begin
                msg_rd = 1'b1;
                d.st   = S_MWB;
            end
            S_MWB: begin
                msg_we = 1'b1;
                if (q.fin) begin
                    d.st = S_FIN;
                end else begin
                    d.mask = NB'(1) << q.pidx;
                    d.crow = q.prow;
                    d.li   = q.li + 1'b1;
                    d.st   = S_LREQ;
                end
            end
            S_FIN: begin
                d.st = S_IDLE;
            end
            default: begin
                d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != S_IDLE);
    assign done      = (q.st == S_FIN);
    assign zero_syn  = q.zero;
    assign overflow  = q.ovf;
    assign weight    = q.wgt;
    assign err_count = q.cnt;

endmodule

// File: rtl/bfl_checker.sv
module bfl_checker #(
    parameter int CAW    = 3,
    parameter int IW     = 3,
    parameter int LW     = 4,
    parameter int LDEPTH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic           zero_syn,
    input logic           overflow,
    input logic [LW-1:0]  err_count,
    input logic           err_we,
    input logic [CAW-1:0] err_wrow,
    input logic [IW-1:0]  err_widx,
    input logic           cor_rd,
    input logic           msg_rd,
    input logic           msg_we,
    input logic [CAW-1:0] msg_addr
);

    p_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_we && $past(err_we)) |-> ({err_wrow, err_widx} > $past({err_wrow, err_widx})));

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_we |=> (err_count == $past(err_count) + 1'b1));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        32'(err_count) <= LDEPTH);

    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !(start && !busy)) |=> overflow);

    p_zero_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        zero_syn |-> ((err_count == '0) && !cor_rd && !msg_we));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_rmw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_we |-> ($past(msg_rd) && (msg_addr == $past(msg_addr))));

endmodule

bind bitflip_locator bfl_checker #(
    .CAW(CAW), .IW(IW), .LW(LW), .LDEPTH(LDEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .zero_syn  (zero_syn),
    .overflow  (overflow),
    .err_count (err_count),
    .err_we    (err_we),
    .err_wrow  (err_wrow),
    .err_widx  (err_widx),
    .cor_rd    (cor_rd),
    .msg_rd    (msg_rd),
    .msg_we    (msg_we),
    .msg_addr  (msg_addr)
);

// File: tb/bitflip_locator_test.sv
`timescale 1ns/1ps
module bitflip_locator_test;

    localparam int NB = 8, CW = 5, SROWS = 4, CROWS = 6, NTHR = 4, LDEPTH = 8;
    localparam int SW = $clog2(SROWS * NB + 1);
    localparam int SAW = $clog2(SROWS), CAW = $clog2(CROWS), IW = $clog2(NB);
    localparam int LW = $clog2(LDEPTH + 1), LAW = $clog2(LDEPTH), TSW = $clog2(NTHR);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic busy, done, zero_syn, overflow;
    logic [SW-1:0] weight;
    logic [LW-1:0] err_count;
    logic cfg_we = 1'b0;
    logic [TSW-1:0] cfg_slot = '0;
    logic [SW-1:0] cfg_brk = '0;
    logic [CW-1:0] cfg_thr = '0;
    logic syn_rd, cor_rd, err_we, err_rd, msg_rd, msg_we;
    logic [SAW-1:0] syn_addr;
    logic [CAW-1:0] cor_addr, err_wrow, err_rrow, msg_addr;
    logic [LAW-1:0] err_waddr, err_raddr;
    logic [IW-1:0] err_widx, err_ridx;
    logic [NB-1:0] syn_rdata, msg_rdata, msg_wdata;
    logic [NB*CW-1:0] cor_rdata;

    always #4 clk = ~clk;

    bitflip_locator #(.NB(NB), .CW(CW), .SROWS(SROWS), .CROWS(CROWS),
                      .NTHR(NTHR), .LDEPTH(LDEPTH)) uut (.*);

    logic [NB-1:0]    syn_mem [SROWS];
    logic [NB*CW-1:0] cor_mem [CROWS];
    logic [NB-1:0]    msg_mem [CROWS];
    logic [NB-1:0]    stg_msg [CROWS];
    logic [CAW-1:0]   el_row [LDEPTH];
    logic [IW-1:0]    el_idx [LDEPTH];
    logic load_msg = 1'b0;
    int syn_rd_n = 0, cor_rd_n = 0, done_n = 0;
    int msg_rd_n [CROWS];
    int msg_we_n [CROWS];

    int checks = 0, fails = 0;
    bit hung = 1'b0;
    int tb_brk [NTHR];
    int tb_thr [NTHR];

    initial begin
        for (int r = 0; r < CROWS; r++) begin
            msg_rd_n[r] = 0;
            msg_we_n[r] = 0;
        end
    end

    // memory models, one cycle read latency
    always @(posedge clk) begin
        if (syn_rd) begin syn_rdata <= syn_mem[syn_addr]; syn_rd_n <= syn_rd_n + 1; end
        if (cor_rd) begin cor_rdata <= cor_mem[cor_addr]; cor_rd_n <= cor_rd_n + 1; end
        if (err_we) begin el_row[err_waddr] <= err_wrow; el_idx[err_waddr] <= err_widx; end
        if (err_rd) begin err_rrow <= el_row[err_raddr]; err_ridx <= el_idx[err_raddr]; end
        if (msg_rd) begin
            msg_rdata <= msg_mem[msg_addr];
            msg_rd_n[msg_addr] <= msg_rd_n[msg_addr] + 1;
        end
        if (load_msg) begin
            for (int r = 0; r < CROWS; r++) msg_mem[r] <= stg_msg[r];
        end else if (msg_we) begin
            msg_mem[msg_addr] <= msg_wdata;
            msg_we_n[msg_addr] <= msg_we_n[msg_addr] + 1;
        end
        if (done) done_n <= done_n + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lookup(input int w);
        int t = (1 << CW) - 1;
        for (int k = 0; k < NTHR; k++) if (w >= tb_brk[k]) t = tb_thr[k];
        return t;
    endfunction

    task automatic cfg_write(input int slot, input int b, input int t);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = TSW'(slot); cfg_brk = SW'(b); cfg_thr = CW'(t);
        @(negedge clk);
        cfg_we = 1'b0;
        tb_brk[slot] = b;
        tb_thr[slot] = t;
    endtask

    task automatic set_elem(input int r, input int j, input int v);
        cor_mem[r][j*CW +: CW] = CW'(v);
    endtask

    task automatic fill_random(input int hi_pct);
        for (int r = 0; r < SROWS; r++)
            syn_mem[r] = ($urandom % 4 == 0) ? '0 : NB'($urandom);
        for (int r = 0; r < CROWS; r++) begin
            stg_msg[r] = NB'($urandom);
            for (int j = 0; j < NB; j++)
                set_elem(r, j, (($urandom % 100) < hi_pct) ? $urandom % 32 : $urandom % 8);
        end
    endtask

    task automatic run_case(input string name, input bit restart_mid);
        int ew, et, ecnt, waited, s0, c0, d0, bad;
        bit eovf;
        int xr [LDEPTH];
        int xi [LDEPTH];
        logic [NB-1:0] exp_msg [CROWS];
        bit hit [CROWS];
        int mr0 [CROWS];
        int mw0 [CROWS];
        if (hung) return;
        ew = 0;
        for (int r = 0; r < SROWS; r++) ew += $countones(syn_mem[r]);
        et = lookup(ew);
        ecnt = 0; eovf = 1'b0;
        for (int r = 0; r < CROWS; r++) begin exp_msg[r] = stg_msg[r]; hit[r] = 1'b0; end
        if (ew != 0) begin
            for (int r = 0; r < CROWS; r++)
                for (int j = 0; j < NB; j++)
                    if (int'(cor_mem[r][j*CW +: CW]) > et) begin
                        if (ecnt < LDEPTH) begin
                            xr[ecnt] = r; xi[ecnt] = j; ecnt++;
                            exp_msg[r][j] = ~exp_msg[r][j];
                            hit[r] = 1'b1;
                        end else eovf = 1'b1;
                    end
        end
        @(negedge clk); load_msg = 1'b1;
        @(negedge clk); load_msg = 1'b0;
        s0 = syn_rd_n; c0 = cor_rd_n; d0 = done_n;
        for (int r = 0; r < CROWS; r++) begin mr0[r] = msg_rd_n[r]; mw0[r] = msg_we_n[r]; end
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (restart_mid) begin
            repeat (3) @(negedge clk);
            chk(busy == 1'b1, "R8", {name, " busy during run"}, int'(busy), 1);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 4000) begin @(negedge clk); waited++; end
        if (!done) begin
            fails++; checks++;
            $display("FAIL R8 %s watchdog actual=%0d expected=%0d", name, 0, 1);
            hung = 1'b1;
            return;
        end
        chk(int'(weight) == ew, "R1", {name, " weight"}, int'(weight), ew);
        chk(syn_rd_n - s0 == SROWS, "R1", {name, " syndrome reads"}, syn_rd_n - s0, SROWS);
        chk(zero_syn == (ew == 0), "R7", {name, " zero flag"}, int'(zero_syn), int'(ew == 0));
        chk(cor_rd_n - c0 == ((ew == 0) ? 0 : CROWS), "R7", {name, " correlation reads"},
            cor_rd_n - c0, (ew == 0) ? 0 : CROWS);
        chk(int'(err_count) == ecnt, "R3", {name, " flagged count"}, int'(err_count), ecnt);
        chk(overflow == eovf, "R5", {name, " overflow"}, int'(overflow), int'(eovf));
        bad = 0;
        for (int k = 0; k < ecnt; k++)
            if (int'(el_row[k]) != xr[k] || int'(el_idx[k]) != xi[k]) bad++;
        chk(bad == 0, "R4", {name, " list order"}, bad, 0);
        bad = 0;
        for (int r = 0; r < CROWS; r++) if (msg_mem[r] !== exp_msg[r]) bad++;
        chk(bad == 0, "R6", {name, " corrected rows"}, bad, 0);
        bad = 0;
        for (int r = 0; r < CROWS; r++)
            if (msg_we_n[r] - mw0[r] != int'(hit[r])) bad++;
        chk(bad == 0, "R6", {name, " rows written"}, bad, 0);
        bad = 0;
        for (int r = 0; r < CROWS; r++)
            if (msg_rd_n[r] - mr0[r] != msg_we_n[r] - mw0[r]) bad++;
        chk(bad == 0, "R9", {name, " read per write"}, bad, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", {name, " done pulse"}, int'(done), 0);
        chk(busy == 1'b0, "R8", {name, " idle after"}, int'(busy), 0);
        repeat (3) @(negedge clk);
        chk(done_n - d0 == 1, "R8", {name, " done count"}, done_n - d0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog global actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NTHR; k++) begin tb_brk[k] = 0; tb_thr[k] = (1 << CW) - 1; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R8", "reset idle", int'(busy), 0);
        chk(overflow == 1'b0, "R5", "reset overflow", int'(overflow), 0);
        chk(err_count == '0, "R4", "reset count", int'(err_count), 0);
        chk(weight == '0, "R1", "reset weight", int'(weight), 0);

        // R2: reset table gives all-ones threshold, nothing flips
        fill_random(60);
        for (int j = 0; j < NB; j++) set_elem(1, j, 31);
        syn_mem[0] = 8'hFF;
        run_case("R2 reset table", 1'b0);

        cfg_write(0, 0, 28);
        cfg_write(1, 6, 12);
        cfg_write(2, 12, 9);
        cfg_write(3, 20, 6);

        // R7: zero syndrome
        fill_random(80);
        for (int r = 0; r < SROWS; r++) syn_mem[r] = '0;
        run_case("R7 zero", 1'b0);

        // R3: equality not flagged, weight 1 picks threshold 28
        fill_random(0);
        for (int r = 0; r < SROWS; r++) syn_mem[r] = '0;
        syn_mem[2] = 8'h10;
        for (int r = 0; r < CROWS; r++) for (int j = 0; j < NB; j++) set_elem(r, j, 28);
        set_elem(2, 5, 29);
        run_case("R3 equal", 1'b0);

        // R5: every element above the lowest threshold
        for (int r = 0; r < SROWS; r++) syn_mem[r] = 8'hFF;
        for (int r = 0; r < CROWS; r++) for (int j = 0; j < NB; j++) set_elem(r, j, 31);
        run_case("R5 dense", 1'b0);

        // R5: flag cleared by the next run; multiple flips in two rows
        fill_random(0);
        syn_mem[0] = 8'h0F; syn_mem[1] = 8'h03; syn_mem[2] = '0; syn_mem[3] = '0;
        set_elem(0, 7, 20); set_elem(0, 1, 20); set_elem(0, 4, 30);
        set_elem(4, 0, 25); set_elem(4, 6, 13);
        run_case("R5 cleared", 1'b0);

        // R2: no slot matches when weight is below the first breakpoint
        cfg_write(0, 3, 2);
        fill_random(90);
        for (int r = 0; r < SROWS; r++) syn_mem[r] = '0;
        syn_mem[3] = 8'h81;
        run_case("R2 no slot", 1'b0);
        cfg_write(0, 0, 28);

        // R8: start while busy is ignored
        fill_random(25);
        run_case("R8 restart", 1'b1);

        for (int n = 0; n < 10; n++) begin
            fill_random(10 + 8 * n);
            run_case("random", 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule